// File: doc/BRIEF.md
# Receive Jabber Watchdog

This block guards a receive path against frames whose carrier never ends. It counts bit times while the receive carrier is high, using a one-cycle bit-time strobe as the unit. When a single carrier burst reaches a fixed trip length, it reports a watchdog timeout. The timeout sets a status flag and raises a one-cycle interrupt request, and a receive controller treats that request as a receive error. The trip length sits between a length that must always pass and a length that must always trip.

After a timeout the status flag stays set until the carrier has been low for a programmable number of bit times. A control input chooses a short or a long release interval. If the carrier comes back during the release interval, the interval starts again. A second control input turns the watchdog off completely. Frame parsing, CRC checking and writing status into packet memory belong to other blocks.

Top module: `jabwd_top`

## Requirements
- R1: A carrier burst that counts fewer than 18432 bit-time strobes never sets the status or raises the interrupt. This covers every burst of 16384 bit times or less.
- R2: The timeout status rises on the clock edge that samples the 18432nd strobe of a burst, counted after its rising cycle. Every burst of 20480 bit times therefore trips.
- R3: With the release select low, a held status clears on the edge that samples the 20th consecutive low-carrier strobe.
- R4: With the release select high, a held status clears on the edge that samples the 44th consecutive low-carrier strobe.
- R5: If the carrier goes high during the release interval, the count of low-carrier strobes restarts from zero.
- R6: While the disable input is high, the status and the interrupt stay low one edge later, and a held status is cleared.
- R7: The interrupt is a single-cycle pulse that coincides with the rise of the status. A burst that continues after the trip raises no second pulse.
- R8: The length count restarts on every rising edge of the carrier. It advances only in cycles where the strobe is high, so strobe-low cycles inside a burst add nothing.
- R9: After reset the status and the interrupt are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| carrier_i | input | 1 | Receive carrier sense |
| bit_tick_i | input | 1 | One-cycle strobe, one per bit time |
| long_release_i | input | 1 | 1 selects the 44-bit release, 0 the 20-bit release |
| wd_disable_i | input | 1 | 1 turns the watchdog off and clears a held timeout |
| timeout_o | output | 1 | Watchdog timeout status, held until released |
| timeout_irq_o | output | 1 | One-cycle interrupt request on timeout |

## Verification
The bench targets the exact trip boundary: a burst of 18431 strobes must stay quiet and the next strobe must trip. A counter that is off by one would trip early or one strobe late. A burst laced with strobe-low cycles exposes a counter that advances on every clock rather than on the strobe. A carrier that returns halfway through the release interval exposes a timer that only pauses instead of restarting, which would release too early. A burst that runs on past the trip exposes an interrupt that fires again on every later strobe. Raising the disable input while a timeout is held must clear that timeout, and a disabled watchdog must stay quiet through a 20480-bit burst. Random bursts with random strobe density, release selection and disable are compared cycle by cycle against a model built from the requirements.

// File: rtl/jabwd_pkg.sv
// Package: shared types for the receive jabber watchdog.
// Assumes: nothing beyond a two-state watchdog controller.
package jabwd_pkg;

    // Watchdog controller state.
    typedef enum logic {
        WD_ARMED   = 1'b0,
        WD_TRIPPED = 1'b1
    } wd_state_e;

endpackage

// File: rtl/jabwd_len_counter.sv
// Module: jabwd_len_counter
// Measures the length of the current carrier burst in bit times and flags the
// strobe on which the burst reaches TRIP_BITS.
// Assumes: bit_tick_i is a one-cycle strobe synchronous to clk; a strobe that
// falls on the rising cycle of carrier is not counted.
module jabwd_len_counter #(
    parameter int TRIP_BITS = 18432
) (
    input  logic clk,
    input  logic rst_n,
    input  logic carrier_i,
    input  logic bit_tick_i,
    output logic hit_o
);
    localparam int CW = $clog2(TRIP_BITS + 1);
    localparam logic [CW-1:0] LIMIT     = CW'(TRIP_BITS);
    localparam logic [CW-1:0] LIMIT_M1  = CW'(TRIP_BITS - 1);

    logic          carrier_q;
    logic [CW-1:0] cnt_q;
    logic          rise;

    assign rise  = carrier_i && !carrier_q;
    assign hit_o = carrier_i && bit_tick_i && !rise && (cnt_q == LIMIT_M1);

    // Remember last carrier value for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) carrier_q <= 1'b0;
        else        carrier_q <= carrier_i;
    end

    // Burst length counter: clear on carrier rise, count strobes, saturate.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (rise)
            cnt_q <= '0;
        else if (carrier_i && bit_tick_i && cnt_q != LIMIT)
            cnt_q <= cnt_q + 1'b1;
    end

    AST_CLEAR_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (carrier_i && !carrier_q) |=> (cnt_q == '0)); // R8
    AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_tick_i && !(carrier_i && !carrier_q)) |=> $stable(cnt_q)); // R8

endmodule

// File: rtl/jabwd_release_timer.sv
// Module: jabwd_release_timer
// While a timeout is held, counts consecutive low-carrier strobes and signals
// when the selected release interval has elapsed.
// Assumes: active_i is high exactly while a timeout is held; any carrier-high
// cycle restarts the interval.
module jabwd_release_timer #(
    parameter int SHORT_REL = 20,
    parameter int LONG_REL  = 44
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    input  logic carrier_i,
    input  logic bit_tick_i,
    input  logic long_sel_i,
    output logic done_o
);
    localparam int MAXREL = (LONG_REL > SHORT_REL) ? LONG_REL : SHORT_REL;
    localparam int RW     = $clog2(MAXREL + 1);

    logic [RW-1:0] cnt_q;
    logic [RW-1:0] target_m1;

    assign target_m1 = long_sel_i ? RW'(LONG_REL - 1) : RW'(SHORT_REL - 1);
    assign done_o    = active_i && !carrier_i && bit_tick_i && (cnt_q >= target_m1);

    // Quiet-time counter: idle when not held, restart on carrier, count strobes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!active_i || carrier_i)
            cnt_q <= '0;
        else if (bit_tick_i && !done_o)
            cnt_q <= cnt_q + 1'b1;
    end

    AST_RESTART_ON_CARRIER: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && carrier_i) |=> (cnt_q == '0)); // R5
    AST_DONE_IS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!carrier_i && $past(active_i) == active_i)); // R3

endmodule

// File: rtl/jabwd_top.sv
// Module: jabwd_top
// Receive jabber watchdog: trips on an over-long carrier burst, holds the
// timeout status until the carrier has been quiet for the selected release
// interval, and pulses an interrupt request once per timeout.
// Assumes: one bit_tick_i strobe per bit time; control inputs are static or
// synchronous to clk.
module jabwd_top #(
    parameter int TRIP_BITS = 18432,
    parameter int SHORT_REL = 20,
    parameter int LONG_REL  = 44
) (
    input  logic clk,
    input  logic rst_n,
    input  logic carrier_i,
    input  logic bit_tick_i,
    input  logic long_release_i,
    input  logic wd_disable_i,
    output logic timeout_o,
    output logic timeout_irq_o
);
    import jabwd_pkg::*;

    wd_state_e state_q;
    logic      hit;
    logic      rel_done;
    logic      irq_q;

    jabwd_len_counter #(.TRIP_BITS(TRIP_BITS)) u_len (
        .clk       (clk),
        .rst_n     (rst_n),
        .carrier_i (carrier_i),
        .bit_tick_i(bit_tick_i),
        .hit_o     (hit)
    );

    jabwd_release_timer #(.SHORT_REL(SHORT_REL), .LONG_REL(LONG_REL)) u_rel (
        .clk       (clk),
        .rst_n     (rst_n),
        .active_i  (state_q == WD_TRIPPED),
        .carrier_i (carrier_i),
        .bit_tick_i(bit_tick_i),
        .long_sel_i(long_release_i),
        .done_o    (rel_done)
    );

    // Controller: arm, trip on length hit, release after quiet interval.
    always_ff @(posedge clk) begin
        if (!rst_n || wd_disable_i)
            state_q <= WD_ARMED;
        else if (state_q == WD_ARMED && hit)
            state_q <= WD_TRIPPED;
        else if (state_q == WD_TRIPPED && rel_done)
            state_q <= WD_ARMED;
    end

    // Interrupt request: one cycle on the arming-to-tripped transition.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= (state_q == WD_ARMED) && hit && !wd_disable_i;
    end

    assign timeout_o     = (state_q == WD_TRIPPED);
    assign timeout_irq_o = irq_q;

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_irq_o |=> !timeout_irq_o); // R7
    AST_IRQ_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_irq_o |-> (timeout_o && !$past(timeout_o))); // R7
    AST_DISABLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        wd_disable_i |=> (!timeout_o && !timeout_irq_o)); // R6
    AST_TRIP_NEEDS_CARRIER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_o) |-> $past(carrier_i)); // R2
    AST_RELEASE_NEEDS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(timeout_o) && !$past(wd_disable_i)) |-> !$past(carrier_i)); // R3

endmodule

// File: tb/jabwd_top_test.sv
module jabwd_top_test;
    localparam int TRIP  = 18432;
    localparam int SREL  = 20;
    localparam int LREL  = 44;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic carrier = 1'b0, tick = 1'b0, rsel = 1'b0, dis = 1'b0;
    logic status, irq;

    int n_cmp = 0, n_bad = 0, cycles = 0, irq_seen = 0;
    string tag = "R9";

    // model state
    bit m_prev = 0, m_state = 0, m_status = 0, m_irq = 0;
    int m_len = 0, m_rel = 0;

    always #2.5 clk = ~clk;

    jabwd_top uut (
        .clk(clk), .rst_n(rst_n), .carrier_i(carrier), .bit_tick_i(tick),
        .long_release_i(rsel), .wd_disable_i(dis),
        .timeout_o(status), .timeout_irq_o(irq)
    );

    function automatic int rel_len(bit sel);
        return sel ? LREL : SREL;
    endfunction

    function automatic bit len_hit(bit car, bit tk, bit rise, int len);
        return car && tk && !rise && (len == TRIP - 1);
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic model_step();
        bit rise, hit, done, was;
        rise = carrier && !m_prev;
        hit  = len_hit(carrier, tick, rise, m_len);
        done = m_state && !carrier && tick && (m_rel >= rel_len(rsel) - 1);
        was  = m_state;
        if (rise) m_len = 0;
        else if (carrier && tick && m_len < TRIP) m_len++;
        if (!m_state || carrier) m_rel = 0;
        else if (tick && !done) m_rel++;
        m_irq = !was && hit && !dis;
        if (dis) m_state = 0;
        else if (!was && hit) m_state = 1;
        else if (was && done) m_state = 0;
        m_status = m_state;
        m_prev = carrier;
    endtask

    // One clock: drive at negedge, model at posedge, compare at next negedge.
    task automatic cyc(bit car, bit tk, bit rs, bit ds);
        carrier = car; tick = tk; rsel = rs; dis = ds;
        @(posedge clk);
        model_step();
        @(negedge clk);
        cycles++;
        if (irq) irq_seen++;
        check(status == m_status, tag, "status", status, m_status);
        check(irq == m_irq, tag, "irq", irq, m_irq);
    endtask

    task automatic burst_on(int ticks, bit gaps, bit rs, bit ds);
        cyc(1, 0, rs, ds);
        burst_more(ticks, gaps, rs, ds);
    endtask

    task automatic burst_more(int ticks, bit gaps, bit rs, bit ds);
        for (int i = 0; i < ticks; i++) begin
            if (gaps && (i % 97 == 0)) cyc(1, 0, rs, ds);
            cyc(1, 1, rs, ds);
        end
    endtask

    task automatic quiet_until_release(bit rs, output int n);
        n = 0;
        while (status && n < 200) begin
            cyc(0, 1, rs, 0);
            n++;
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (195000) @(posedge clk);
        n_bad++;
        $display("FAIL all: watchdog expired, actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int n;
        void'($urandom(32'd7719));
        // R9: reset state
        repeat (3) @(negedge clk);
        check(status == 0, "R9", "status in reset", status, 0);
        check(irq == 0, "R9", "irq in reset", irq, 0);
        rst_n = 1'b1;
        cyc(0, 0, 0, 0);

        // R1 + R8: 16383 strobes with strobe-low gaps stay quiet
        tag = "R1";
        burst_on(16383, 1, 0, 0);
        check(status == 0, "R8", "gapped 16383-bit burst status", status, 0);
        repeat (5) cyc(0, 1, 0, 0);

        // R1/R2 boundary, then R7 single pulse
        tag = "R2";
        irq_seen = 0;
        burst_on(TRIP - 1, 0, 0, 0);
        check(status == 0, "R1", "status after 18431 strobes", status, 0);
        burst_more(1, 0, 0, 0);
        check(status == 1, "R2", "status at 18432nd strobe", status, 1);
        check(irq == 1, "R7", "irq at trip", irq, 1);
        burst_more(20480 - TRIP, 0, 0, 0);
        check(irq_seen == 1, "R7", "irq pulses over 20480-bit burst", irq_seen, 1);

        // R5: carrier returns mid-release, then R3 short release
        tag = "R5";
        repeat (10) cyc(0, 1, 0, 0);
        repeat (3) cyc(1, 1, 0, 0);
        quiet_until_release(0, n);
        check(n == SREL, "R5", "quiet strobes after restart", n, SREL);
        check(n == SREL, "R3", "short release length", n, SREL);

        // R4: long release
        tag = "R4";
        burst_on(TRIP, 0, 1, 0);
        check(status == 1, "R4", "trip before long release", status, 1);
        quiet_until_release(1, n);
        check(n == LREL, "R4", "long release length", n, LREL);

        // R6: disable clears a held timeout
        tag = "R6";
        burst_on(TRIP, 0, 1, 0);
        cyc(0, 1, 1, 1);
        check(status == 0, "R6", "held status after disable", status, 0);

        // R6: disabled watchdog ignores a 20480-bit burst
        irq_seen = 0;
        burst_on(20480, 0, 0, 1);
        check(status == 0, "R6", "status with disable", status, 0);
        check(irq_seen == 0, "R6", "irq pulses with disable", irq_seen, 0);
        repeat (5) cyc(0, 1, 0, 1);

        // Random bursts and gaps, compared every cycle
        tag = "R8";
        for (int f = 0; f < 30; f++) begin
            int len = 1 + int'($urandom % 2500);
            bit rs  = $urandom % 2;
            bit ds  = ($urandom % 8) == 0;
            int dens = 1 + int'($urandom % 4);
            cyc(1, 0, rs, ds);
            for (int i = 0; i < len; i++)
                cyc(1, ($urandom % 4) < dens, rs, ds);
            for (int g = 0; g < 1 + int'($urandom % 60); g++)
                cyc(0, $urandom % 2, $urandom % 2, ds);
        end
        check(status == 0, "R1", "status after random short bursts", status, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule